// File: doc/BRIEF.md
# CPU Clock Frequency-Change Sequencer

This block steps a processor clock domain between five performance levels. Level 0 is the fastest (nominal 1200 MHz), and levels 1 to 4 run at nominal 1000, 800, 500 and 200 MHz. A request carries a target level. The sequencer then works out whether the PLL multiplier and pre-divider change between the current and target levels. If they do, it performs a full relock; if they do not, it rewrites only the post-divider field of the PLL control word. It also rewrites the two clock-divider configuration words for the new level.

The order of the two updates depends on the direction of the move. When the clock speeds up, the dividers are changed before the PLL. When it slows down, the PLL is changed before the dividers. Every update that affects the clock generator is followed by a wait on the status the generator returns: mux status, PLL lock, or divider-busy bits. Each wait is limited by a programmable cycle timeout. If a timeout expires, the sequencer raises an error flag, abandons the change and keeps the current level.

All register updates are read-modify-write. The new word is formed from the readback input of that register, so bits outside the fields the sequencer owns are kept.

Top module: `freq_step_seq`

## Requirements
- R1: After reset the sequencer is idle. `busy`, `done`, `errorFlag`, `coreMuxAlt` and every write strobe are low, and `curLevel` equals the RESET_LEVEL parameter (default 2).
- R2: The PLL word places M in bits 25:16, P in bits 13:8 and S in bits 2:0. The per-level (M,P,S) values are: level 0 (150,3,1), level 1 (250,6,1), level 2 (200,6,1), level 3 (250,6,2), level 4 (200,6,3). Every other bit of `pllWordOut` is copied from `pllWordIn`.
- R3: A full relock runs only when {M,P} of the target differs from {M,P} of the current level. Otherwise a single PLL write changes only bits 2:0, with no mux switch, no lock-time write and no lock wait.
- R4: When the target index is lower than the current one, both divider words are written before the PLL update. When it is higher, the PLL update comes before the divider words.
- R5: A relock proceeds in this order:
  - `coreMuxAlt` rises, then the sequencer waits for `muxStatus` == 2.
  - `lockTimeWe` pulses with `lockTimeWord` = LOCK_TIME (default 4050).
  - The PLL word is written, then the sequencer waits for `pllLocked`.
  - `coreMuxAlt` falls, then the sequencer waits for `muxStatus` == 1.
- R6: In divider word 0, the field with index k (k = 0 to 6: core, core-M0, core-M1, peripheral, trace bus, debug APB, PLL) sits at bits 4k+2:4k. The field values per level are:
  - levels 0 and 1: 0,3,7,3,4,1,7
  - levels 2 and 3: 0,3,7,3,3,1,7
  - level 4: 0,1,3,1,3,1,0

  After word 0 is written, the sequencer waits until `div0Status` bits 0,4,...,24 are all clear. It then writes word 1, with the copy divider (5,4,3,3,3 for levels 0 to 4) in bits 6:4 and the monitor divider 0 in bits 2:0. It then waits until `div1Status` bits 0 and 4 are clear. Other bits of both divider words are copied from their readback inputs, and the other status bits are ignored.
- R7: Each wait ignores its status input in the first cycle of the wait, so stale status left over from before the write cannot end it.
- R8: A valid request for the current level raises `done` for one cycle in the cycle after the request, writes nothing and never raises `busy`.
- R9: A request while `busy` is high is ignored. A request with a level above 4 is ignored at all times.
- R10: If a wait has not seen its condition after `timeoutLimit` counted cycles, `errorFlag` rises, `busy` falls, `done` stays low and `curLevel` keeps its old value. `errorFlag` stays high until the next valid request.
- R11: At the end of a change, `done` pulses for one cycle. In that same cycle `busy` is low and `curLevel` shows the target level. `curLevel` changes at no other time.
- R12: The four write strobes (`pllWe`, `lockTimeWe`, `div0We`, `div1We`) are single-cycle pulses, and at most one of them is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe |
| reqLevel | input | 3 | Target level of the request |
| timeoutLimit | input | TMO_W | Cycle limit for each wait |
| pllWordIn | input | 32 | Readback of the PLL control word |
| pllLocked | input | 1 | PLL lock indication |
| muxStatus | input | 3 | Core mux status (1 main PLL, 2 alternate PLL) |
| div0WordIn | input | 32 | Readback of divider word 0 |
| div0Status | input | 32 | Divider word 0 busy status |
| div1WordIn | input | 32 | Readback of divider word 1 |
| div1Status | input | 32 | Divider word 1 busy status |
| pllWordOut | output | 32 | New PLL control word |
| pllWe | output | 1 | PLL word write strobe |
| lockTimeWord | output | 20 | Lock-time value |
| lockTimeWe | output | 1 | Lock-time write strobe |
| coreMuxAlt | output | 1 | Core mux select, 1 selects the alternate PLL |
| div0WordOut | output | 32 | New divider word 0 |
| div0We | output | 1 | Divider word 0 write strobe |
| div1WordOut | output | 32 | New divider word 1 |
| div1We | output | 1 | Divider word 1 write strobe |
| busy | output | 1 | A change is in progress |
| done | output | 1 | One-cycle completion pulse |
| errorFlag | output | 1 | Last change timed out |
| curLevel | output | 3 | Current level |

## Verification
The hardest situations to reach from the ports are a timeout in the middle of a relock and the stale-status case of the first wait cycle. A timeout in the middle of a relock leaves the mux on the alternate PLL with half of the writes done. The bench reaches it with a switch in its clock-generator model that holds lock low forever. It then checks that the writes already issued match the expected prefix, that the level is unchanged, and that a following post-divider-only change clears the error. For stale status, the model raises divider-busy and drops lock only in the cycle after it sees a write. A sequencer that trusted the status of the first wait cycle would therefore return the mux before lock, or write divider word 1 while word 0 is still busy. The monitor checks for exactly those conditions.

// File: rtl/freq_step_pkg.sv
`timescale 1ns/1ps
package freq_step_pkg;

  localparam int NUM_LVL = 5;
  localparam int LVL_W   = 3;
  localparam int WORD_W  = 32;

  localparam logic [WORD_W-1:0] PLL_FIELD_MASK = 32'h03FF_3F07;
  localparam logic [WORD_W-1:0] PLL_S_MASK     = 32'h0000_0007;
  localparam logic [WORD_W-1:0] DIV0_MASK      = 32'h0777_7777;
  localparam logic [WORD_W-1:0] DIV0_STAT_MASK = 32'h0111_1111;
  localparam logic [WORD_W-1:0] DIV1_MASK      = 32'h0000_0077;
  localparam logic [WORD_W-1:0] DIV1_STAT_MASK = 32'h0000_0011;

  // Control-to-datapath strobes
  typedef struct packed {
    logic accept;
    logic ackSame;
    logic wrDiv0;
    logic wrDiv1;
    logic wrLockTime;
    logic wrPllFull;
    logic wrPllS;
    logic setMuxAlt;
    logic setMuxMain;
    logic clrTimer;
    logic commit;
    logic raiseError;
  } seqStrobe_t;

  function automatic logic [WORD_W-1:0] packPll(input logic [9:0] m, input logic [5:0] p,
                                                input logic [2:0] s);
    return {6'd0, m, 2'd0, p, 5'd0, s};
  endfunction

  function automatic logic [WORD_W-1:0] pllFields(input logic [LVL_W-1:0] lvl);
    case (lvl)
      3'd0:    return packPll(10'd150, 6'd3, 3'd1);
      3'd1:    return packPll(10'd250, 6'd6, 3'd1);
      3'd2:    return packPll(10'd200, 6'd6, 3'd1);
      3'd3:    return packPll(10'd250, 6'd6, 3'd2);
      default: return packPll(10'd200, 6'd6, 3'd3);
    endcase
  endfunction

  // fields: 7 x 3 bits, field k in bits 3k+2:3k, placed at word bits 4k+2:4k
  function automatic logic [WORD_W-1:0] packDiv0(input logic [20:0] fields);
    logic [WORD_W-1:0] w;
    w = '0;
    for (int k = 0; k < 7; k++) w[4*k +: 3] = fields[3*k +: 3];
    return w;
  endfunction

  // concatenation order: pll, dbg, trace, periph, coreM1, coreM0, core
  function automatic logic [WORD_W-1:0] div0Fields(input logic [LVL_W-1:0] lvl);
    case (lvl)
      3'd0, 3'd1: return packDiv0({3'd7, 3'd1, 3'd4, 3'd3, 3'd7, 3'd3, 3'd0});
      3'd2, 3'd3: return packDiv0({3'd7, 3'd1, 3'd3, 3'd3, 3'd7, 3'd3, 3'd0});
      default:    return packDiv0({3'd0, 3'd1, 3'd3, 3'd1, 3'd3, 3'd1, 3'd0});
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] div1Fields(input logic [LVL_W-1:0] lvl);
    logic [2:0] copyDiv;
    case (lvl)
      3'd0:    copyDiv = 3'd5;
      3'd1:    copyDiv = 3'd4;
      default: copyDiv = 3'd3;
    endcase
    return {24'd0, 1'b0, copyDiv, 1'b0, 3'd0};
  endfunction

endpackage

// File: rtl/freq_step_ctrl.sv
`timescale 1ns/1ps
module freq_step_ctrl
  import freq_step_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       levelValid,
  input  logic       sameLevel,
  input  logic       relockNeeded,
  input  logic       goingFaster,
  input  logic       settled,
  input  logic       timedOut,
  input  logic       div0Clear,
  input  logic       div1Clear,
  input  logic       muxAtAlt,
  input  logic       muxAtMain,
  input  logic       pllLocked,
  output seqStrobe_t stb,
  output logic       busy
);

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_DIV0_WR, S_DIV0_WAIT, S_DIV1_WR, S_DIV1_WAIT,
    S_PLL_S, S_MUX_ALT, S_ALT_WAIT, S_LOCKT, S_PLL_FULL, S_LOCK_WAIT,
    S_MUX_MAIN, S_MAIN_WAIT, S_FINISH
  } seqState_t;

  seqState_t state, nxt;
  seqState_t pllEntry, pllExit, divExit;
  logic      waitCond;
  seqState_t waitNext;
  logic      inWait;

  assign pllEntry = relockNeeded ? S_MUX_ALT : S_PLL_S;
  assign pllExit  = goingFaster ? S_FINISH : S_DIV0_WR;
  assign divExit  = goingFaster ? pllEntry : S_FINISH;

  // Condition and successor of the current wait state
  always_comb begin
    inWait   = 1'b1;
    waitCond = 1'b0;
    waitNext = S_IDLE;
    case (state)
      S_DIV0_WAIT: begin waitCond = div0Clear; waitNext = S_DIV1_WR;  end
      S_DIV1_WAIT: begin waitCond = div1Clear; waitNext = divExit;    end
      S_ALT_WAIT:  begin waitCond = muxAtAlt;  waitNext = S_LOCKT;    end
      S_LOCK_WAIT: begin waitCond = pllLocked; waitNext = S_MUX_MAIN; end
      S_MAIN_WAIT: begin waitCond = muxAtMain; waitNext = pllExit;    end
      default:     inWait = 1'b0;
    endcase
  end

  always_comb begin
    stb = '0;
    nxt = state;
    if (inWait) begin
      if (settled && waitCond) begin
        nxt = waitNext;
      end else if (timedOut) begin
        stb.raiseError = 1'b1;
        nxt = S_IDLE;
      end
    end else begin
      case (state)
        S_IDLE: begin
          if (reqValid && levelValid) begin
            if (sameLevel) begin
              stb.ackSame = 1'b1;
            end else begin
              stb.accept = 1'b1;
              nxt = S_START;
            end
          end
        end
        S_START:    nxt = goingFaster ? S_DIV0_WR : pllEntry;
        S_DIV0_WR:  begin stb.wrDiv0 = 1'b1; stb.clrTimer = 1'b1; nxt = S_DIV0_WAIT; end
        S_DIV1_WR:  begin stb.wrDiv1 = 1'b1; stb.clrTimer = 1'b1; nxt = S_DIV1_WAIT; end
        S_PLL_S:    begin stb.wrPllS = 1'b1; nxt = pllExit; end
        S_MUX_ALT:  begin stb.setMuxAlt = 1'b1; stb.clrTimer = 1'b1; nxt = S_ALT_WAIT; end
        S_LOCKT:    begin stb.wrLockTime = 1'b1; nxt = S_PLL_FULL; end
        S_PLL_FULL: begin stb.wrPllFull = 1'b1; stb.clrTimer = 1'b1; nxt = S_LOCK_WAIT; end
        S_MUX_MAIN: begin stb.setMuxMain = 1'b1; stb.clrTimer = 1'b1; nxt = S_MAIN_WAIT; end
        S_FINISH:   begin stb.commit = 1'b1; nxt = S_IDLE; end
        default:    nxt = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nxt;
  end

  assign busy = (state != S_IDLE);

endmodule

// File: rtl/freq_step_dp.sv
`timescale 1ns/1ps
module freq_step_dp
  import freq_step_pkg::*;
#(
  parameter int                 TMO_W       = 16,
  parameter logic [LVL_W-1:0]   RESET_LEVEL = 3'd2
)(
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        stb,
  input  logic [LVL_W-1:0]  reqLevel,
  input  logic [TMO_W-1:0]  timeoutLimit,
  input  logic [WORD_W-1:0] pllWordIn,
  input  logic [2:0]        muxStatus,
  input  logic [WORD_W-1:0] div0WordIn,
  input  logic [WORD_W-1:0] div0Status,
  input  logic [WORD_W-1:0] div1WordIn,
  input  logic [WORD_W-1:0] div1Status,
  output logic              levelValid,
  output logic              sameLevel,
  output logic              relockNeeded,
  output logic              goingFaster,
  output logic              settled,
  output logic              timedOut,
  output logic              div0Clear,
  output logic              div1Clear,
  output logic              muxAtAlt,
  output logic              muxAtMain,
  output logic [WORD_W-1:0] pllWordOut,
  output logic              pllWe,
  output logic              lockTimeWe,
  output logic              coreMuxAlt,
  output logic [WORD_W-1:0] div0WordOut,
  output logic              div0We,
  output logic [WORD_W-1:0] div1WordOut,
  output logic              div1We,
  output logic              done,
  output logic              errorFlag,
  output logic [LVL_W-1:0]  curLevel
);

  localparam logic [LVL_W-1:0] MAX_LVL  = LVL_W'(NUM_LVL - 1);
  localparam logic [WORD_W-1:0] MP_MASK = PLL_FIELD_MASK & ~PLL_S_MASK;

  logic [LVL_W-1:0]  tgtLevel;
  logic [TMO_W-1:0]  tmoCnt;
  logic [WORD_W-1:0] tgtPll, curPll;

  assign tgtPll       = pllFields(tgtLevel);
  assign curPll       = pllFields(curLevel);
  assign levelValid   = (reqLevel <= MAX_LVL);
  assign sameLevel    = (reqLevel == curLevel);
  assign relockNeeded = ((tgtPll & MP_MASK) != (curPll & MP_MASK));
  assign goingFaster  = (tgtLevel < curLevel);
  assign settled      = (tmoCnt != '0);
  assign timedOut     = settled && (tmoCnt >= timeoutLimit);
  assign div0Clear    = ((div0Status & DIV0_STAT_MASK) == '0);
  assign div1Clear    = ((div1Status & DIV1_STAT_MASK) == '0);
  assign muxAtAlt     = (muxStatus == 3'd2);
  assign muxAtMain    = (muxStatus == 3'd1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curLevel    <= RESET_LEVEL;
      tgtLevel    <= RESET_LEVEL;
      pllWordOut  <= '0;
      div0WordOut <= '0;
      div1WordOut <= '0;
      pllWe       <= 1'b0;
      lockTimeWe  <= 1'b0;
      div0We      <= 1'b0;
      div1We      <= 1'b0;
      coreMuxAlt  <= 1'b0;
      done        <= 1'b0;
      errorFlag   <= 1'b0;
      tmoCnt      <= '0;
    end else begin
      pllWe      <= stb.wrPllFull | stb.wrPllS;
      lockTimeWe <= stb.wrLockTime;
      div0We     <= stb.wrDiv0;
      div1We     <= stb.wrDiv1;
      done       <= stb.commit | stb.ackSame;

      if (stb.accept) tgtLevel <= reqLevel;
      if (stb.accept || stb.ackSame) errorFlag <= 1'b0;
      else if (stb.raiseError)       errorFlag <= 1'b1;
      if (stb.commit) curLevel <= tgtLevel;

      if (stb.wrPllFull)
        pllWordOut <= (pllWordIn & ~PLL_FIELD_MASK) | tgtPll;
      else if (stb.wrPllS)
        pllWordOut <= (pllWordIn & ~PLL_S_MASK) | (tgtPll & PLL_S_MASK);
      if (stb.wrDiv0) div0WordOut <= (div0WordIn & ~DIV0_MASK) | div0Fields(tgtLevel);
      if (stb.wrDiv1) div1WordOut <= (div1WordIn & ~DIV1_MASK) | div1Fields(tgtLevel);

      if (stb.setMuxAlt)       coreMuxAlt <= 1'b1;
      else if (stb.setMuxMain) coreMuxAlt <= 1'b0;

      if (stb.clrTimer)       tmoCnt <= '0;
      else if (tmoCnt != '1) tmoCnt <= tmoCnt + 1'b1;
    end
  end

endmodule

// File: rtl/freq_step_seq.sv
`timescale 1ns/1ps
module freq_step_seq
  import freq_step_pkg::*;
#(
  parameter int               TMO_W       = 16,
  parameter logic [LVL_W-1:0] RESET_LEVEL = 3'd2,
  parameter logic [19:0]      LOCK_TIME   = 20'd4050
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [LVL_W-1:0]  reqLevel,
  input  logic [TMO_W-1:0]  timeoutLimit,
  input  logic [WORD_W-1:0] pllWordIn,
  input  logic              pllLocked,
  input  logic [2:0]        muxStatus,
  input  logic [WORD_W-1:0] div0WordIn,
  input  logic [WORD_W-1:0] div0Status,
  input  logic [WORD_W-1:0] div1WordIn,
  input  logic [WORD_W-1:0] div1Status,
  output logic [WORD_W-1:0] pllWordOut,
  output logic              pllWe,
  output logic [19:0]       lockTimeWord,
  output logic              lockTimeWe,
  output logic              coreMuxAlt,
  output logic [WORD_W-1:0] div0WordOut,
  output logic              div0We,
  output logic [WORD_W-1:0] div1WordOut,
  output logic              div1We,
  output logic              busy,
  output logic              done,
  output logic              errorFlag,
  output logic [LVL_W-1:0]  curLevel
);

  seqStrobe_t stb;
  logic levelValid, sameLevel, relockNeeded, goingFaster, settled, timedOut;
  logic div0Clear, div1Clear, muxAtAlt, muxAtMain;

  assign lockTimeWord = LOCK_TIME;

  freq_step_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .levelValid(levelValid),
    .sameLevel(sameLevel), .relockNeeded(relockNeeded), .goingFaster(goingFaster),
    .settled(settled), .timedOut(timedOut), .div0Clear(div0Clear), .div1Clear(div1Clear),
    .muxAtAlt(muxAtAlt), .muxAtMain(muxAtMain), .pllLocked(pllLocked),
    .stb(stb), .busy(busy)
  );

  freq_step_dp #(.TMO_W(TMO_W), .RESET_LEVEL(RESET_LEVEL)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .reqLevel(reqLevel), .timeoutLimit(timeoutLimit),
    .pllWordIn(pllWordIn), .muxStatus(muxStatus), .div0WordIn(div0WordIn),
    .div0Status(div0Status), .div1WordIn(div1WordIn), .div1Status(div1Status),
    .levelValid(levelValid), .sameLevel(sameLevel), .relockNeeded(relockNeeded),
    .goingFaster(goingFaster), .settled(settled), .timedOut(timedOut),
    .div0Clear(div0Clear), .div1Clear(div1Clear), .muxAtAlt(muxAtAlt), .muxAtMain(muxAtMain),
    .pllWordOut(pllWordOut), .pllWe(pllWe), .lockTimeWe(lockTimeWe), .coreMuxAlt(coreMuxAlt),
    .div0WordOut(div0WordOut), .div0We(div0We), .div1WordOut(div1WordOut), .div1We(div1We),
    .done(done), .errorFlag(errorFlag), .curLevel(curLevel)
  );

endmodule

// File: rtl/freq_step_chk.sv
`timescale 1ns/1ps
module freq_step_chk
  import freq_step_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              pllWe,
  input logic              lockTimeWe,
  input logic              div0We,
  input logic              div1We,
  input logic              done,
  input logic              busy,
  input logic              errorFlag,
  input logic              coreMuxAlt,
  input logic [LVL_W-1:0]  curLevel,
  input logic [WORD_W-1:0] pllWordIn,
  input logic [WORD_W-1:0] pllWordOut,
  input logic [WORD_W-1:0] div0WordIn,
  input logic [WORD_W-1:0] div0WordOut
);

  a_r12_strobe_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({pllWe, lockTimeWe, div0We, div1We}));

  a_r11_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  a_r11_level_with_done: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(curLevel) |-> done);

  a_r10_error_no_done: assert property (@(posedge clk) disable iff (!rstN)
    errorFlag |-> !done);

  a_r2_pll_keeps_bits: assert property (@(posedge clk) disable iff (!rstN)
    pllWe |-> ((pllWordOut & ~PLL_FIELD_MASK) == ($past(pllWordIn) & ~PLL_FIELD_MASK)));

  a_r6_div0_keeps_bits: assert property (@(posedge clk) disable iff (!rstN)
    div0We |-> ((div0WordOut & ~DIV0_MASK) == ($past(div0WordIn) & ~DIV0_MASK)));

  a_r5_relock_on_alt: assert property (@(posedge clk) disable iff (!rstN)
    (pllWe && (pllWordOut[25:8] != $past(pllWordIn[25:8]))) |-> coreMuxAlt);

  a_r5_locktime_on_alt: assert property (@(posedge clk) disable iff (!rstN)
    lockTimeWe |-> coreMuxAlt);

endmodule

bind freq_step_seq freq_step_chk u_chk (.*);

// File: tb/freq_step_seq_test.sv
`timescale 1ns/1ps
module freq_step_seq_test;

  localparam logic [31:0] PLL_INIT  = 32'hC000_00F0;
  localparam logic [31:0] DIV0_INIT = 32'h8888_8888;
  localparam logic [31:0] DIV1_INIT = 32'hA5A5_0088;
  localparam logic [19:0] LOCK_VAL  = 20'd4050;
  localparam int K_DIV0 = 1, K_DIV1 = 2, K_LOCKT = 3, K_PLL = 4, K_MALT = 5, K_MMAIN = 6;

  logic        clk = 0;
  logic        rstN = 0;
  logic        reqValid = 0;
  logic [2:0]  reqLevel = 0;
  logic [15:0] timeoutLimit = 16'd100;
  logic [31:0] pllWordIn, div0WordIn, div1WordIn, div0Status, div1Status;
  logic        pllLocked;
  logic [2:0]  muxStatus;
  logic [31:0] pllWordOut, div0WordOut, div1WordOut;
  logic [19:0] lockTimeWord;
  logic        pllWe, lockTimeWe, coreMuxAlt, div0We, div1We, busy, done, errorFlag;
  logic [2:0]  curLevel;

  int checks = 0, errors = 0, doneCount = 0;
  logic [35:0] expQ[$];
  logic [2:0]  expLevel = 3'd2;
  bit          lockStuck = 0;

  // clock-generator model state
  logic [31:0] mPll, mDiv0, mDiv1;
  int          lockCnt, d0Cnt, d1Cnt, muxCnt;
  logic        muxApplied, prevMux;
  logic [2:0]  mMux;

  always #4 clk = ~clk;

  freq_step_seq uut (.*);

  assign pllWordIn  = mPll;
  assign div0WordIn = mDiv0;
  assign div1WordIn = mDiv1;
  assign pllLocked  = (lockCnt == 0) && !lockStuck;
  assign muxStatus  = mMux;
  assign div0Status = 32'h8000_0000 | ((d0Cnt != 0) ? 32'h0111_1111 : 32'h0);
  assign div1Status = 32'h0000_0100 | ((d1Cnt != 0) ? 32'h0000_0011 : 32'h0);

  always @(posedge clk) begin
    if (!rstN) begin
      mPll <= PLL_INIT | bPll(3'd2); mDiv0 <= DIV0_INIT; mDiv1 <= DIV1_INIT;
      lockCnt <= 0; d0Cnt <= 0; d1Cnt <= 0; muxCnt <= 0; muxApplied <= 0; mMux <= 3'd1;
    end else begin
      if (pllWe) begin
        mPll <= pllWordOut;
        if (pllWordOut[25:8] != mPll[25:8]) lockCnt <= 6;
      end else if (lockCnt != 0) lockCnt <= lockCnt - 1;
      if (div0We) begin mDiv0 <= div0WordOut; d0Cnt <= 4; end
      else if (d0Cnt != 0) d0Cnt <= d0Cnt - 1;
      if (div1We) begin mDiv1 <= div1WordOut; d1Cnt <= 3; end
      else if (d1Cnt != 0) d1Cnt <= d1Cnt - 1;
      if (coreMuxAlt != muxApplied) begin
        muxApplied <= coreMuxAlt; muxCnt <= 3; mMux <= 3'd4;
      end else if (muxCnt != 0) begin
        muxCnt <= muxCnt - 1;
        if (muxCnt == 1) mMux <= muxApplied ? 3'd2 : 3'd1;
      end
    end
  end

  // expected values, written from the requirements
  function automatic logic [31:0] bPll(input logic [2:0] l);
    logic [9:0] m; logic [5:0] p; logic [2:0] s;
    case (l)
      3'd0: begin m = 150; p = 3; s = 1; end
      3'd1: begin m = 250; p = 6; s = 1; end
      3'd2: begin m = 200; p = 6; s = 1; end
      3'd3: begin m = 250; p = 6; s = 2; end
      default: begin m = 200; p = 6; s = 3; end
    endcase
    return (32'(m) << 16) | (32'(p) << 8) | 32'(s);
  endfunction

  function automatic logic [31:0] bDiv0(input logic [2:0] l);
    int f[7];
    logic [31:0] w = 0;
    if (l <= 1)      f = '{0, 3, 7, 3, 4, 1, 7};
    else if (l <= 3) f = '{0, 3, 7, 3, 3, 1, 7};
    else             f = '{0, 1, 3, 1, 3, 1, 0};
    for (int k = 0; k < 7; k++) w = w | (32'(f[k]) << (4 * k));
    return w;
  endfunction

  function automatic logic [31:0] bDiv1(input logic [2:0] l);
    int c = (l == 0) ? 5 : (l == 1) ? 4 : 3;
    return 32'(c) << 4;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic seen(input int k, input logic [31:0] d, input string req);
    logic [35:0] e;
    if (expQ.size() == 0) begin
      chk(0, req, "unexpected write kind", 32'(k), 32'hFFFF_FFFF);
    end else begin
      e = expQ.pop_front();
      chk(e[35:32] == 4'(k), req, "write kind / order", 32'(k), 32'(e[35:32]));
      chk(e[31:0] == d, req, "write value", d, e[31:0]);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rstN) begin
      if (div0We) seen(K_DIV0, div0WordOut, "R6");
      if (div1We) begin
        seen(K_DIV1, div1WordOut, "R6");
        chk((div0Status & 32'h0111_1111) == 0, "R7", "div word 0 still busy at word 1 write",
            div0Status, 32'h0);
      end
      if (lockTimeWe) begin
        seen(K_LOCKT, 32'(lockTimeWord), "R5");
        chk(muxStatus == 3'd2, "R7", "mux status at lock-time write", 32'(muxStatus), 32'd2);
      end
      if (pllWe) seen(K_PLL, pllWordOut, "R2");
      if (coreMuxAlt && !prevMux) seen(K_MALT, 0, "R5");
      if (!coreMuxAlt && prevMux) begin
        seen(K_MMAIN, 0, "R5");
        chk(pllLocked, "R7", "mux returned before lock", 32'(pllLocked), 32'd1);
      end
      if (done) begin
        doneCount++;
        chk(d1Cnt == 0 && muxCnt == 0, "R11", "done before status settled", 32'(d1Cnt), 32'd0);
      end
    end
    prevMux = coreMuxAlt;
  end

  task automatic request(input logic [2:0] l);
    @(negedge clk); reqValid = 1; reqLevel = l;
    @(negedge clk); reqValid = 0;
  endtask

  task automatic push(input int k, input logic [31:0] d);
    expQ.push_back({4'(k), d});
  endtask

  // interfere: issue a level-0 request part-way through (R9)
  task automatic doChange(input logic [2:0] l, input bit stuck, input bit interfere);
    bit faster, relock, gotDone, gotErr;
    logic [31:0] pllExp;
    faster = l < expLevel;
    relock = (bPll(l) & 32'h03FF_3F00) != (bPll(expLevel) & 32'h03FF_3F00);
    pllExp = relock ? ((mPll & ~32'h03FF_3F07) | bPll(l)) : ((mPll & ~32'h7) | (bPll(l) & 32'h7));
    if (faster) begin
      push(K_DIV0, (mDiv0 & ~32'h0777_7777) | bDiv0(l));
      push(K_DIV1, (mDiv1 & ~32'h77) | bDiv1(l));
    end
    if (relock) begin
      push(K_MALT, 0); push(K_LOCKT, 32'(LOCK_VAL)); push(K_PLL, pllExp);
      if (!stuck) push(K_MMAIN, 0);
    end else push(K_PLL, pllExp);
    if (!faster) begin
      push(K_DIV0, (mDiv0 & ~32'h0777_7777) | bDiv0(l));
      push(K_DIV1, (mDiv1 & ~32'h77) | bDiv1(l));
    end
    request(l);
    chk(busy, "R4", "busy after accepted request", 32'(busy), 32'd1);
    if (interfere) begin
      repeat (3) @(negedge clk);
      reqValid = 1; reqLevel = 3'd0;
      @(negedge clk); reqValid = 0;
    end
    gotDone = 0; gotErr = 0;
    for (int i = 0; i < 3000; i++) begin
      if (done) begin gotDone = 1; break; end
      if (errorFlag) begin gotErr = 1; break; end
      @(negedge clk);
    end
    if (stuck) begin
      chk(gotErr && !gotDone, "R10", "timeout raises error", 32'(gotErr), 32'd1);
      chk(curLevel == expLevel, "R10", "level kept on timeout", 32'(curLevel), 32'(expLevel));
      chk(!busy, "R10", "idle after timeout", 32'(busy), 32'd0);
    end else begin
      expLevel = l;
      chk(gotDone, "R11", "done pulse", 32'(gotDone), 32'd1);
      chk(curLevel == l, "R11", "level updated", 32'(curLevel), 32'(l));
      chk(!busy && !errorFlag, "R11", "idle, no error at done", 32'({busy, errorFlag}), 32'd0);
    end
    chk(expQ.size() == 0, relock ? "R5" : "R3", "writes missing (R4 order)",
        32'(expQ.size()), 32'd0);
    @(negedge clk);
    chk(!done, "R11", "done lasts one cycle", 32'(done), 32'd0);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int dc;
    repeat (4) @(negedge clk);
    chk(!busy && !done && !errorFlag && !coreMuxAlt, "R1", "reset outputs",
        32'({busy, done, errorFlag, coreMuxAlt}), 32'd0);
    chk(!pllWe && !div0We && !div1We && !lockTimeWe, "R1", "reset strobes",
        32'({pllWe, div0We, div1We, lockTimeWe}), 32'd0);
    chk(curLevel == 3'd2, "R1", "reset level", 32'(curLevel), 32'd2);
    rstN = 1;
    repeat (3) @(negedge clk);

    // R8: same level
    request(3'd2);
    chk(done, "R8", "done next cycle for same level", 32'(done), 32'd1);
    chk(!busy, "R8", "no busy for same level", 32'(busy), 32'd0);
    repeat (3) @(negedge clk);

    // slower, post-divider only (R3, R4)
    doChange(3'd4, 0, 0);
    // faster, post-divider only, with request while busy (R9)
    doChange(3'd2, 0, 1);
    repeat (20) @(negedge clk);
    chk(curLevel == 3'd2 && !busy, "R9", "request while busy ignored",
        32'(curLevel), 32'd2);

    // R9: invalid level
    dc = doneCount;
    request(3'd5);
    repeat (10) @(negedge clk);
    chk(!busy && doneCount == dc && curLevel == 3'd2, "R9", "level 5 ignored",
        32'(doneCount - dc), 32'd0);

    // relocks (R5) faster then slower (R4)
    doChange(3'd0, 0, 0);
    doChange(3'd3, 0, 0);

    // R10: timeout while waiting for lock
    timeoutLimit = 16'd20;
    lockStuck = 1;
    doChange(3'd0, 1, 0);
    chk(errorFlag, "R10", "error flag held", 32'(errorFlag), 32'd1);
    lockStuck = 0;
    timeoutLimit = 16'd100;
    repeat (10) @(negedge clk);
    chk(errorFlag, "R10", "error flag still held", 32'(errorFlag), 32'd1);
    // recovery: post-divider-only change clears the error (R10, R3)
    doChange(3'd1, 0, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule